// File: doc/BRIEF.md
# Hardware Spinlock Bank

A bank of hardware semaphores shared by several bus masters. Each lock is one Taken flag. A master claims a lock by reading its register. A zero in the read data means the claim succeeded. A one means another master already holds the lock. The holder frees the lock by writing zero to the register. All accesses go through one valid/ready slave port, one at a time, so test-and-set on any lock is atomic between masters.

Alongside the locks sit a configuration word and a status word. The configuration word reports fixed power-management settings and holds a self-clearing soft-reset control. While a soft reset runs, every lock is cleared and lock accesses are held off. The status word shows, one bit per group of 64 locks, whether any lock in that group is held. A power controller may ask the block to go idle. The block grants this only while no slave request is pending or in flight, and it withdraws the grant before it serves any new request.

Top module: `hw_spinlock`

## Requirements
- R1: After the hardware reset (rst_ni low), all locks are free, the status word reads 0, idle_ack_o is 0, rsp_valid_o is 0 and req_ready_o is 1.
- R2: Lock i sits at byte address 0x800 + 4*i. Address bits [1:0] are ignored. A read of a free lock returns 0 and marks it taken. A read of a taken lock returns 1 and leaves it taken.
- R3: A write with wdata bit 0 equal to 0 to a lock frees it. A write with wdata bit 0 equal to 1 has no effect on the lock.
- R4: The status word at 0x004 has bit b set exactly when some lock with index in 64*b .. 64*b+63 is taken. Its other bits are 0.
- R5: The configuration word at 0x000 reads 0x111 when no soft reset is running. That is bit 0 = 1 (autogating), bit 2 = 0 (wake-up off), bits [4:3] = 2'b10 (smart idle), bit 8 = 1 (clock may stop when idle), and all other bits 0. Writes to these fixed fields have no effect.
- R6: A write to 0x000 with wdata bit 1 set starts a soft reset that lasts SRST_CYCLES cycles. During the soft reset, bit 1 of the configuration word reads 1, so the word reads 0x113. Bit 1 returns to 0 by itself when the soft reset ends. The soft reset leaves every lock free.
- R7: While a soft reset runs, req_ready_o is 0 for any request to a lock address. Requests to the configuration and status words are still accepted.
- R8: idle_ack_o rises one cycle after idle_req_i is seen high with no request valid, no response pending and no soft reset running. It falls one cycle after idle_req_i goes low.
- R9: While idle_ack_o is 1, req_ready_o is 0. A request that is valid while idle_ack_o is 1 makes idle_ack_o fall on the next cycle, and the request is then served.
- R10: Every accepted request gets rsp_valid_o high for exactly one cycle, on the cycle after it is accepted. Writes return data 0. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | 32 | Read data |
| idle_req_i | input | 1 | Idle request from power controller |
| idle_ack_o | output | 1 | Idle acknowledge |

## Verification
The hardest situation to reach from the ports is a lock request that arrives while a soft reset is still running. It matters because that request must stall and must then find its lock already freed. The bench writes the reset bit and sends a configuration read and a lock read straight after it, with no gap. This catches both the read-back of the running reset and the stall. A second directed sequence raises a request while idle is already granted, and checks that the grant drops before the request is served. Random traffic aims at locks on both sides of the 64-lock group boundary.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned BANK_LOCKS  = 64;
  localparam int unsigned SRST_BIT    = 1;
  localparam logic [1:0]  IDLE_SMART  = 2'b10;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CFG  = 2'd1,
    ACC_STAT = 2'd2,
    ACC_LOCK = 2'd3
  } acc_e;

  function automatic logic [DATA_W-1:0] cfg_word(input logic srst_busy);
    logic [DATA_W-1:0] v;
    v          = '0;
    v[0]       = 1'b1;        // autogating
    v[SRST_BIT] = srst_busy;
    v[2]       = 1'b0;        // wake-up disabled
    v[4:3]     = IDLE_SMART;
    v[8]       = 1'b1;        // interface clock may stop in idle
    return v;
  endfunction

endpackage

// File: rtl/spl_srst_ctrl.sv
module spl_srst_ctrl #(
  parameter int unsigned SRST_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  a_r6_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);

endmodule

// File: rtl/spl_idle_ctrl.sv
module spl_idle_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_req_i,
  input  logic req_valid_i,
  input  logic busy_i,
  output logic idle_ack_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= idle_req_i && !req_valid_i && !busy_i;
  end

  assign idle_ack_o = ack_q;

  a_r8_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_req_i |=> !idle_ack_o);
  a_r8_ack_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_req_i && (req_valid_i || busy_i)) |=> !idle_ack_o);
  a_r9_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && req_valid_i) |=> !idle_ack_o);

endmodule

// File: rtl/spl_lock_array.sv
module spl_lock_array #(
  parameter int unsigned NUM_LOCKS = 128,
  parameter int unsigned BANK_SIZE = 64,
  localparam int unsigned NUM_BANKS = NUM_LOCKS / BANK_SIZE,
  localparam int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 acq_i,
  input  logic                 rel_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LOCKS-1:0] taken_o,
  output logic [NUM_BANKS-1:0] bank_any_o
);
  logic [NUM_LOCKS-1:0] taken_q;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    logic hit;
    assign hit = (idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          taken_q[i] <= 1'b0;
      else if (clr_i)       taken_q[i] <= 1'b0;
      else if (acq_i && hit) taken_q[i] <= 1'b1;
      else if (rel_i && hit) taken_q[i] <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_any_o[b] = |taken_q[b*BANK_SIZE +: BANK_SIZE];
  end

  assign taken_o = taken_q;

  a_r2_acquire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq_i && !clr_i) |=> taken_q[$past(idx_i)]);
  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !clr_i) |=> !taken_q[$past(idx_i)]);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (taken_q == '0));
  a_r7_no_access_in_srst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !(acq_i || rel_i));

endmodule

// File: rtl/hw_spinlock.sv
module hw_spinlock #(
  parameter int unsigned NUM_LOCKS   = 128,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SRST_CYCLES = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  output logic                              req_ready_o,
  input  logic                              req_write_i,
  input  logic [ADDR_W-1:0]                 req_addr_i,
  input  logic [spinlock_pkg::DATA_W-1:0]   req_wdata_i,
  output logic                              rsp_valid_o,
  output logic [spinlock_pkg::DATA_W-1:0]   rsp_rdata_o,
  input  logic                              idle_req_i,
  output logic                              idle_ack_o
);
  import spinlock_pkg::*;

  localparam int unsigned NUM_BANKS = NUM_LOCKS / BANK_LOCKS;
  localparam int unsigned IDX_W     = $clog2(NUM_LOCKS);
  localparam int unsigned WORD_W    = ADDR_W - 3;

  acc_e               acc;
  logic [IDX_W-1:0]   idx;
  logic [WORD_W-1:0]  word;
  logic               srst_busy, lock_stall, fire;
  logic               acq, rel, srst_start;
  logic [NUM_LOCKS-1:0] taken;
  logic [NUM_BANKS-1:0] bank_any;
  logic [DATA_W-1:0]  rd_d, stat_word;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_rdata_q;

  // Decode: top address bit selects lock region, word index below it.
  assign word = req_addr_i[ADDR_W-2:2];
  assign idx  = req_addr_i[IDX_W+1:2];

  always_comb begin
    acc = ACC_NONE;
    if (req_addr_i[ADDR_W-1]) begin
      if (32'(word) < NUM_LOCKS) acc = ACC_LOCK;
    end else if (word == WORD_W'(0)) begin
      acc = ACC_CFG;
    end else if (word == WORD_W'(1)) begin
      acc = ACC_STAT;
    end
  end

  assign lock_stall  = srst_busy && (acc == ACC_LOCK);
  assign req_ready_o = !idle_ack_o && !lock_stall;
  assign fire        = req_valid_i && req_ready_o;
  assign acq         = fire && !req_write_i && (acc == ACC_LOCK);
  assign rel         = fire &&  req_write_i && (acc == ACC_LOCK) && !req_wdata_i[0];
  assign srst_start  = fire &&  req_write_i && (acc == ACC_CFG)  && req_wdata_i[SRST_BIT];

  always_comb begin
    stat_word = '0;
    stat_word[NUM_BANKS-1:0] = bank_any;
  end

  always_comb begin
    rd_d = '0;
    if (!req_write_i) begin
      unique case (acc)
        ACC_CFG:  rd_d = cfg_word(srst_busy);
        ACC_STAT: rd_d = stat_word;
        ACC_LOCK: rd_d = {{(DATA_W-1){1'b0}}, taken[idx]};
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= fire;
      if (fire) rsp_rdata_q <= rd_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  spl_srst_ctrl #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (srst_start),
    .active_o(srst_busy)
  );

  spl_lock_array #(.NUM_LOCKS(NUM_LOCKS), .BANK_SIZE(BANK_LOCKS)) u_locks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (srst_busy),
    .acq_i     (acq),
    .rel_i     (rel),
    .idx_i     (idx),
    .taken_o   (taken),
    .bank_any_o(bank_any)
  );

  spl_idle_ctrl u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_req_i (idle_req_i),
    .req_valid_i(req_valid_i),
    .busy_i     (rsp_valid_q || srst_busy),
    .idle_ack_o (idle_ack_o)
  );

  a_r10_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(fire)) |-> 1'b0);
  a_r9_no_accept_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ack_o |-> !fire);

endmodule

// File: tb/hw_spinlock_test.sv
module hw_spinlock_test;
  localparam int unsigned NL = 128;
  localparam int unsigned SC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, idle_req = 1'b0, idle_ack;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit exp_taken [NL];

  always #10 clk = ~clk;  // 50 MHz

  hw_spinlock #(.NUM_LOCKS(NL), .ADDR_W(12), .SRST_CYCLES(SC)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .idle_req_i(idle_req), .idle_ack_o(idle_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] lock_addr(input int i);
    return 12'h800 + 12'(i * 4);
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    for (int i = 0; i < NL; i++) if (exp_taken[i]) s[i/64] = 1'b1;
    return s;
  endfunction

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    #1;
    stalls = 0;
    while (!req_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid", 32'(rsp_valid), 32'd1);
    rd = rsp_rdata;
    @(negedge clk);
    check("R10 single pulse", 32'(rsp_valid), 32'd0);
  endtask

  task automatic rd_lock(input int i);
    logic [31:0] rd; int st;
    access(1'b0, lock_addr(i), '0, rd, st);
    check("R2 acquire", rd, {31'b0, exp_taken[i]});
    exp_taken[i] = 1'b1;
  endtask

  task automatic wr_lock(input int i, input bit v);
    logic [31:0] rd; int st;
    access(1'b1, lock_addr(i), {31'b0, v}, rd, st);
    check("R10 write data", rd, 32'd0);
    if (!v) exp_taken[i] = 1'b0;
  endtask

  task automatic rd_status();
    logic [31:0] rd; int st;
    access(1'b0, 12'h004, '0, rd, st);
    check("R4 status", rd, exp_status());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd; int st;
    repeat (3) @(negedge clk);
    #1;
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 idle_ack", 32'(idle_ack), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 ready", 32'(req_ready), 1);
    rd_status();
    check("R1 status zero", exp_status(), 0);

    // R5 fixed config and write to fixed fields
    access(1'b0, 12'h000, '0, rd, st);
    check("R5 cfg", rd, 32'h111);
    access(1'b1, 12'h000, 32'hFFFF_FFFD, rd, st);
    access(1'b0, 12'h000, '0, rd, st);
    check("R5 cfg fixed", rd, 32'h111);
    access(1'b0, 12'h010, '0, rd, st);
    check("R10 unmapped", rd, 0);

    // R2/R3 directed
    rd_lock(63); rd_lock(63);
    wr_lock(63, 1'b1); rd_lock(63);   // R3 write 1 ignored
    rd_status();
    wr_lock(63, 1'b0); rd_lock(63);   // R3 release then retake
    rd_lock(64); rd_status();

    // Random mix
    for (int k = 0; k < 600; k++) begin
      int i, op;
      int picks[6] = '{0, 1, 63, 64, 65, 127};
      op = $urandom_range(0, 5);
      i  = ($urandom_range(0, 1) == 0) ? picks[$urandom_range(0, 5)] : $urandom_range(0, NL-1);
      case (op)
        0, 1: rd_lock(i);
        2:    wr_lock(i, 1'b0);
        3:    wr_lock(i, 1'b1);
        4:    rd_status();
        default: begin
          access(1'b0, 12'h000, '0, rd, st);
          check("R5 cfg random", rd, 32'h111);
        end
      endcase
    end

    // R6/R7 soft reset with lock access right behind it
    rd_lock(5); rd_lock(70); rd_status();
    access(1'b1, 12'h000, 32'h2, rd, st);
    access(1'b0, 12'h000, '0, rd, st);
    check("R6 cfg busy", rd, 32'h113);
    check("R7 cfg not stalled", 32'(st), 0);
    for (int i = 0; i < NL; i++) exp_taken[i] = 1'b0;
    access(1'b0, lock_addr(70), '0, rd, st);
    check("R7 stalled", 32'(st > 0 && st <= SC), 1);
    check("R6 lock cleared", rd, 0);
    exp_taken[70] = 1'b1;
    rd_status();
    access(1'b0, 12'h000, '0, rd, st);
    check("R6 self clear", rd, 32'h111);
    rd_lock(5);

    // R8 idle handshake
    @(negedge clk); idle_req = 1'b1;
    @(negedge clk); #1;
    check("R8 ack rise", 32'(idle_ack), 1);
    check("R9 ready low", 32'(req_ready), 0);
    idle_req = 1'b0;
    @(negedge clk); #1;
    check("R8 ack fall", 32'(idle_ack), 0);

    // R9 request while acked
    idle_req = 1'b1;
    @(negedge clk); #1;
    check("R8 ack rise 2", 32'(idle_ack), 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = lock_addr(5); #1;
    check("R9 ready held", 32'(req_ready), 0);
    @(negedge clk); #1;
    check("R9 ack dropped", 32'(idle_ack), 0);
    check("R9 ready back", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 served", 32'(rsp_valid), 1);
    check("R2 taken read", rsp_rdata, 1);
    @(negedge clk); #1;
    check("R8 ack pending rsp", 32'(idle_ack), 0);
    @(negedge clk); #1;
    check("R8 ack regained", 32'(idle_ack), 1);
    idle_req = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule